// File: doc/BRIEF.md
# Pipelined Flash Page Command Sequencer

This block takes one multi-page command at a time from a host: a start block, a start page and a page count. It turns that command into a series of single-page operations on a simple flash-device handshake. Each operation is a one-cycle `dev_start` pulse, with `dev_op`, `dev_block` and `dev_page` held, and the device answers later with a one-cycle `dev_done` and a `dev_fail` flag. The direction of a command comes from a mode flag. With the flag clear, each page is loaded into a buffer on the device side and then held until the host claims it with a data access. With the flag set, each page waits until the host supplies its data through a data access, and only then is the device told to program it.

The command slot is freed when the last page starts, not when it ends. At that moment a command-complete pulse fires, and a new command may be accepted. The new command's first page still waits until the engine has finished the last page of the old one. Separate pulses report the end of a final explicit load and the end of a final program. A failed program raises a failure pulse and captures the block and page that failed.

Three configuration inputs choose the device sequencing. Cache-read chains reads, cache-program chains writes, and multi-plane programs pairs of blocks that alternate even and odd.

Top module: `flash_pipe_seq`

## Requirements
- R1: A command with a non-zero count is accepted when `cmd_valid` is high and no command is held. `cmd_busy` is high from the next cycle until the last page of the command starts. A command offered while `cmd_busy` is high is discarded and never produces a device operation.
- R2: `mode_wr` (1 = write-ahead, 0 = read-ahead) follows `cfg_wr_ahead` one cycle later while no command is held. While a command is held, changes of `cfg_wr_ahead` are ignored.
- R3: When the engine is idle, a read-ahead command has its first `dev_start` exactly two clock edges after the edge that samples `cmd_valid`.
- R4: After the `dev_done` of a read page, `page_ready` rises and stays high. Until `acc_valid` arrives there is no `acc_ack` and no further `dev_start`. `acc_valid` gives an `acc_ack` pulse with `page_ready` low on the next cycle, and the next page's `dev_start` follows one cycle after that.
- R5: In write-ahead mode there is no `dev_start` for a page until the host raises `acc_valid`. The program `dev_start` and `acc_ack` then pulse together on the next cycle.
- R6: `irq_cmd_comp` pulses together with the `dev_start` of the last page of a command, and `cmd_busy` drops at the same time. A command accepted after that point does not start until the last page has been completed.
- R7: `irq_prog_comp` pulses on the cycle after the `dev_done` of the last page of a write-ahead command, and at no other time.
- R8: `irq_load_comp` pulses on the cycle after the `dev_done` of the last read page only when that page used the plain load op (code 0).
- R9: A `dev_done` with `dev_fail` high on a program gives an `irq_prog_fail` pulse and captures that page's block and page in `err_block`/`err_page`. The capture holds until the next failure.
- R10: Read op codes are: plain load = 0, cache read = 1, cache read end = 2. With `cfg_cache_rd` set and a count above 1, every page except the last uses 1 and the last uses 2. Otherwise every page uses 0.
- R11: Write op codes are: program = 3, cache program = 4, multi-plane program = 5. The last page always uses 3. Earlier pages use 5 if `cfg_multiplane` is set, else 4 if `cfg_cache_wr` is set, else 3.
- R12: Without multi-plane, page i of a command goes to the start block at start page + i.
- R13: With multi-plane in write-ahead mode, page i goes to the start block with its least significant bit replaced by bit 0 of i, at start page + floor(i/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_ahead | input | 1 | Requested mode: 1 write-ahead, 0 read-ahead |
| cfg_cache_rd | input | 1 | Use cache-read sequencing |
| cfg_cache_wr | input | 1 | Use cache-program sequencing |
| cfg_multiplane | input | 1 | Use multi-plane programming with even/odd block order |
| cmd_valid | input | 1 | Host offers a command |
| cmd_block | input | BLK_W | Start block |
| cmd_page | input | PG_W | Start page |
| cmd_count | input | CNT_W | Number of pages |
| cmd_busy | output | 1 | A command is held; new commands are discarded |
| mode_wr | output | 1 | Mode in effect |
| acc_valid | input | 1 | Host data access for the current page |
| acc_ack | output | 1 | Data access taken |
| page_ready | output | 1 | A loaded read page waits for the host |
| dev_start | output | 1 | Start one device operation |
| dev_op | output | 3 | Device operation code |
| dev_block | output | BLK_W | Device block address |
| dev_page | output | PG_W | Device page address |
| dev_done | input | 1 | Device operation finished |
| dev_fail | input | 1 | Finished operation failed |
| irq_cmd_comp | output | 1 | Command-complete pulse |
| irq_load_comp | output | 1 | Last explicit load finished |
| irq_prog_comp | output | 1 | Last program finished |
| irq_prog_fail | output | 1 | A program failed |
| err_block | output | BLK_W | Block of the latest failed program |
| err_page | output | PG_W | Page of the latest failed program |

## Verification
Every output is a register. A response is due on the cycle after the edge that samples its cause: `cmd_busy` after acceptance, the `dev_start` that follows a data access, and the interrupts and `page_ready` that follow `dev_done`. The one exception is the first read launch, which comes one cycle later still. The bench drives inputs on falling edges, holds each stimulus for exactly one cycle, and samples on the very next falling edge. Where a requirement says something does not happen, the bench samples the quiet outputs over several idle cycles between stimuli.

// File: rtl/flash_pipe_seq.sv
module flash_pipe_seq #(
  parameter int BLK_W = 10,
  parameter int PG_W  = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_ahead,
  input  logic             cfg_cache_rd,
  input  logic             cfg_cache_wr,
  input  logic             cfg_multiplane,
  input  logic             cmd_valid,
  input  logic [BLK_W-1:0] cmd_block,
  input  logic [PG_W-1:0]  cmd_page,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             cmd_busy,
  output logic             mode_wr,
  input  logic             acc_valid,
  output logic             acc_ack,
  output logic             page_ready,
  output logic             dev_start,
  output logic [2:0]       dev_op,
  output logic [BLK_W-1:0] dev_block,
  output logic [PG_W-1:0]  dev_page,
  input  logic             dev_done,
  input  logic             dev_fail,
  output logic             irq_cmd_comp,
  output logic             irq_load_comp,
  output logic             irq_prog_comp,
  output logic             irq_prog_fail,
  output logic [BLK_W-1:0] err_block,
  output logic [PG_W-1:0]  err_page
);
  localparam logic [2:0] OP_LOAD = 3'd0, OP_CRD = 3'd1, OP_CRD_END = 3'd2,
                         OP_PROG = 3'd3, OP_CPROG = 3'd4, OP_MPPROG = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_RWAIT, S_RHOST, S_WHOST, S_WWAIT} st_t;
  st_t st;

  logic             q_vld, mode_q, cur_last;
  logic [BLK_W-1:0] q_blk;
  logic [PG_W-1:0]  q_pg;
  logic [CNT_W-1:0] q_cnt, q_idx;

  wire             l_last = (q_idx == q_cnt - 1'b1);
  wire             mp     = mode_q && cfg_multiplane;
  wire [BLK_W-1:0] l_blk  = mp ? {q_blk[BLK_W-1:1], q_idx[0]} : q_blk;
  wire [PG_W-1:0]  l_pg   = q_pg + PG_W'(mp ? (q_idx >> 1) : q_idx);
  wire [2:0]       rd_op  = (cfg_cache_rd && q_cnt > 1) ? (l_last ? OP_CRD_END : OP_CRD) : OP_LOAD;
  wire [2:0]       wr_op  = l_last ? OP_PROG : mp ? OP_MPPROG : cfg_cache_wr ? OP_CPROG : OP_PROG;

  assign cmd_busy = q_vld;
  assign mode_wr  = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      q_vld <= 1'b0; mode_q <= 1'b0; cur_last <= 1'b0;
      q_blk <= '0; q_pg <= '0; q_cnt <= '0; q_idx <= '0;
      acc_ack <= 1'b0; page_ready <= 1'b0;
      dev_start <= 1'b0; dev_op <= OP_LOAD; dev_block <= '0; dev_page <= '0;
      irq_cmd_comp <= 1'b0; irq_load_comp <= 1'b0;
      irq_prog_comp <= 1'b0; irq_prog_fail <= 1'b0;
      err_block <= '0; err_page <= '0;
    end else begin
      dev_start <= 1'b0; acc_ack <= 1'b0;
      irq_cmd_comp <= 1'b0; irq_load_comp <= 1'b0;
      irq_prog_comp <= 1'b0; irq_prog_fail <= 1'b0;
      if (!q_vld && !cmd_valid) mode_q <= cfg_wr_ahead;
      if (cmd_valid && !q_vld && cmd_count != '0) begin
        q_vld <= 1'b1;
        q_blk <= cmd_block; q_pg <= cmd_page; q_cnt <= cmd_count; q_idx <= '0;
      end
      case (st)
        S_IDLE: if (q_vld) begin
          dev_block <= l_blk; dev_page <= l_pg; cur_last <= l_last;
          q_idx <= q_idx + 1'b1;
          if (!mode_q) begin
            dev_op <= rd_op; dev_start <= 1'b1; st <= S_RWAIT;
            if (l_last) begin q_vld <= 1'b0; irq_cmd_comp <= 1'b1; end
          end else begin
            dev_op <= wr_op; st <= S_WHOST;
          end
        end
        S_RWAIT: if (dev_done) begin
          page_ready <= 1'b1;
          irq_load_comp <= cur_last && dev_op == OP_LOAD;
          st <= S_RHOST;
        end
        S_RHOST: if (acc_valid) begin
          page_ready <= 1'b0; acc_ack <= 1'b1; st <= S_IDLE;
        end
        S_WHOST: if (acc_valid) begin
          acc_ack <= 1'b1; dev_start <= 1'b1; st <= S_WWAIT;
          if (cur_last) begin q_vld <= 1'b0; irq_cmd_comp <= 1'b1; end
        end
        S_WWAIT: if (dev_done) begin
          irq_prog_comp <= cur_last;
          if (dev_fail) begin
            irq_prog_fail <= 1'b1; err_block <= dev_block; err_page <= dev_page;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_accept_needs_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_vld) |-> $past(cmd_valid));
  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld && $past(q_vld)) |-> $stable(mode_q));
  assert_ready_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (page_ready && !acc_valid) |=> page_ready);
  assert_prog_after_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_start && dev_op >= OP_PROG) |-> acc_ack);
  assert_comp_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmd_comp |-> dev_start);
  assert_load_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_load_comp |-> $past(dev_done));
  assert_err_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_prog_fail |-> ($stable(err_block) && $stable(err_page)));
endmodule

// File: tb/sim_flash_pipe_seq.sv
`timescale 1ns/1ps
module sim_flash_pipe_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr_ahead = 0, cfg_cache_rd = 0, cfg_cache_wr = 0, cfg_multiplane = 0;
  logic cmd_valid = 0; logic [9:0] cmd_block = 0; logic [5:0] cmd_page = 0; logic [7:0] cmd_count = 0;
  logic acc_valid = 0, dev_done = 0, dev_fail = 0;
  logic cmd_busy, mode_wr, acc_ack, page_ready, dev_start;
  logic [2:0] dev_op; logic [9:0] dev_block, err_block; logic [5:0] dev_page, err_page;
  logic irq_cmd_comp, irq_load_comp, irq_prog_comp, irq_prog_fail;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  flash_pipe_seq u0 (.clk, .rst_n, .cfg_wr_ahead, .cfg_cache_rd, .cfg_cache_wr, .cfg_multiplane,
    .cmd_valid, .cmd_block, .cmd_page, .cmd_count, .cmd_busy, .mode_wr, .acc_valid, .acc_ack,
    .page_ready, .dev_start, .dev_op, .dev_block, .dev_page, .dev_done, .dev_fail,
    .irq_cmd_comp, .irq_load_comp, .irq_prog_comp, .irq_prog_fail, .err_block, .err_page);

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int b, input int p, input int c);
    @(negedge clk); cmd_valid = 1; cmd_block = 10'(b); cmd_page = 6'(p); cmd_count = 8'(c);
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({tag, " no dev_start"}, dev_start, 0);
      chk({tag, " no acc_ack"}, acc_ack, 0);
    end
  endtask

  task automatic done(input bit fail);
    dev_done = 1; dev_fail = fail;
    @(negedge clk); dev_done = 0; dev_fail = 0;
  endtask

  task automatic acc();
    acc_valid = 1;
    @(negedge clk); acc_valid = 0;
  endtask

  // one read page, entered at the negedge showing its dev_start
  task automatic rd_page(input int op, input int b, input int p, input bit last, input bit comp_chk);
    chk("R10 read op", dev_op, op);
    chk("R12 read block", dev_block, b);
    chk("R12 read page", dev_page, p);
    if (comp_chk) chk("R6 cmd_comp on last start", irq_cmd_comp, last);
    done(0);
    chk("R4 page_ready after load", page_ready, 1);
    chk("R8 load_comp", irq_load_comp, (last && op == 0));
    quiet(3, "R4 hold");
    chk("R4 still ready", page_ready, 1);
    acc();
    chk("R4 acc_ack", acc_ack, 1);
    chk("R4 ready cleared", page_ready, 0);
  endtask

  task automatic read_run(input int b, input int p, input int c, input bit cache);
    cfg_cache_rd = cache;
    issue(b, p, c);
    chk("R1 busy after accept", cmd_busy, 1);
    for (int i = 0; i < c; i++) begin
      int op;
      @(negedge clk);
      chk(i == 0 ? "R3 immediate first load" : "R4 next page after ack", dev_start, 1);
      op = (cache && c > 1) ? ((i == c - 1) ? 2 : 1) : 0;
      rd_page(op, b, p + i, i == c - 1, 1);
    end
    chk("R6 busy dropped", cmd_busy, 0);
    cfg_cache_rd = 0;
  endtask

  task automatic wr_page(input int op, input int b, input int p, input bit last, input bit fail);
    quiet(3, "R5 wait host data");
    acc();
    chk("R5 acc_ack", acc_ack, 1);
    chk("R5 program start", dev_start, 1);
    chk("R11 write op", dev_op, op);
    chk("R12/R13 write block", dev_block, b);
    chk("R12/R13 write page", dev_page, p);
    chk("R6 cmd_comp", irq_cmd_comp, last);
    chk("R6 busy", cmd_busy, !last);
    done(fail);
    chk("R7 prog_comp", irq_prog_comp, last);
    chk("R9 prog_fail", irq_prog_fail, fail);
    if (fail) begin
      chk("R9 err block", err_block, b);
      chk("R9 err page", err_page, p);
    end
  endtask

  task automatic write_run(input int b, input int p, input int c, input int fail_at);
    issue(b, p, c);
    for (int i = 0; i < c; i++) begin
      int op, eb, ep;
      @(negedge clk);
      op = (i == c - 1) ? 3 : cfg_multiplane ? 5 : cfg_cache_wr ? 4 : 3;
      eb = cfg_multiplane ? ((b & ~1) | (i & 1)) : b;
      ep = cfg_multiplane ? p + i / 2 : p + i;
      wr_page(op, eb, ep, i == c - 1, i == fail_at);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset busy", cmd_busy, 0);
    chk("R2 reset mode", mode_wr, 0);
    chk("R4 reset ready", page_ready, 0);
    chk("R5 reset dev_start", dev_start, 0);
    chk("R6 reset cmd_comp", irq_cmd_comp, 0);
    chk("R9 reset err", err_block, 0);
  endtask

  task automatic t_set_mode(input bit m);
    @(negedge clk); cfg_wr_ahead = m;
    @(negedge clk);
    chk("R2 mode follows when empty", mode_wr, m);
  endtask

  task automatic t_overlap();
    issue(20, 3, 2);
    @(negedge clk);
    rd_page(0, 20, 3, 0, 1);
    @(negedge clk);
    chk("R6 last start", dev_start, 1);
    chk("R6 cmd_comp with last start", irq_cmd_comp, 1);
    chk("R6 busy drops", cmd_busy, 0);
    issue(40, 9, 1);
    chk("R6 new cmd held", cmd_busy, 1);
    quiet(3, "R6 new cmd waits");
    rd_page(0, 20, 4, 1, 0);
    @(negedge clk);
    chk("R6 new cmd starts", dev_start, 1);
    rd_page(0, 40, 9, 1, 1);
  endtask

  task automatic t_reject();
    t_set_mode(1);
    issue(8, 1, 2);
    issue(99, 30, 5);
    chk("R1 busy during reject", cmd_busy, 1);
    @(negedge clk); cfg_wr_ahead = 0;
    @(negedge clk);
    chk("R2 mode change ignored", mode_wr, 1);
    wr_page(3, 8, 1, 0, 0);
    @(negedge clk);
    wr_page(3, 8, 2, 1, 0);
    quiet(6, "R1 rejected cmd never runs");
    chk("R2 mode applies when empty", mode_wr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    read_run(5, 2, 3, 0);
    read_run(12, 7, 3, 1);
    read_run(12, 0, 1, 1);
    t_overlap();
    t_reject();
    t_set_mode(1);
    write_run(3, 4, 3, 1);
    chk("R9 err held after later success", err_page, 5);
    cfg_cache_wr = 1; write_run(17, 0, 3, 2); cfg_cache_wr = 0;
    cfg_multiplane = 1; write_run(6, 10, 4, -1); cfg_multiplane = 0;
    chk("R9 err still held", err_block, 17);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule